// File: doc/BRIEF.md
# Profiling Event Counter Bank

This block holds five small performance counters. Each one tallies a class of core activity that the core reports cycle by cycle. The five classes are: extra cycles of multi-cycle non-memory instructions plus fetch stalls, exception handling overhead, sleep cycles, load/store cycles beyond the first, and instructions that retire in zero cycles. Each counter has its own enable. When a counter wraps past its top value, it raises a one-cycle overflow strobe. A trace unit downstream turns that strobe into a packet.

A counter restarts from zero when its enable turns on. It counts only while enabled. Software can load any value into a counter through a simple write port. Loads take precedence over counting and never produce a strobe. A build-time option removes all counters for configurations that have no profiling support.

Top module: `prof_cnt_bank`

## Requirements
- R1: After reset every counter value is 0 and every overflow strobe is low.
- R2: In the cycle after a counter's enable goes from 0 to 1, that counter reads 0 with no strobe. The clear wins over any increment or write in that same cycle.
- R3: The extra-cycle counter (select 0) adds exactly 1 per enabled cycle in which the extra-cycle qualifier, the fetch-stall qualifier, or both are high.
- R4: When an increment carries the counter past 255, the value wraps modulo 256. The strobe for that counter is high for exactly the one cycle in which the wrapped value first appears.
- R5: The load/store counter (select 3) adds 1 per cycle that the core flags as a load/store cycle after the first. A 4-cycle access therefore adds 3 and a 2-cycle access adds 1.
- R6: A write with wr_en high and wr_sel equal to a counter's select loads wr_data on the next edge. It takes precedence over an increment in the same cycle and raises no strobe.
- R7: A counter whose enable is low holds its value and raises no strobe whatever its qualifier does, but it still accepts writes.
- R8: The folded counter (select 4) adds the reported number of zero-cycle instructions each cycle (0 to 3 with the default 2-bit input). The strobe comes from the carry out of bit 7, so 254 plus 3 gives 1 with a strobe.
- R9: The exception-overhead counter (select 1) and the sleep counter (select 2) each add 1 per enabled cycle in which their own qualifier is high, independently of each other.
- R10: When built with IMPLEMENTED = 0, all counter outputs stay 0 and no strobe ever rises, even under writes and qualifiers.
- R11: A write whose wr_sel is 5, 6 or 7 changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 5 | Per-counter enable, bit index equals select code |
| cpi_extra | input | 1 | Current cycle is an extra cycle of a non-load/store instruction |
| fetch_stall | input | 1 | Current cycle is an instruction fetch stall |
| exc_cycle | input | 1 | Current cycle is spent in exception entry, return or pre-emption |
| sleep_cycle | input | 1 | Core is sleeping this cycle |
| lsu_extra | input | 1 | Current cycle is a load/store cycle after the first |
| fold_num | input | FOLD_W (2) | Number of zero-cycle instructions retired this cycle |
| wr_en | input | 1 | Counter write strobe |
| wr_sel | input | 3 | Counter select for the write |
| wr_data | input | CNT_W (8) | Value to load |
| cnt_val | output | 5*CNT_W (40) | Counter values, counter k at bits k*CNT_W upward |
| ovf_evt | output | 5 | One-cycle overflow strobes, bit index equals select code |

## Verification
The bench builds one instance with the defaults, CNT_W = 8 and FOLD_W = 2. At that width the wrap at 255 takes only a few writes and increments to reach. The 2-bit folded input can step over the wrap point instead of landing on it, which exercises carry-based strobe detection. A second instance with IMPLEMENTED = 0 receives the same stimulus, so the removed-counter variant is checked against live traffic, including writes and wraps.

// File: rtl/prof_cnt_pkg.sv
package prof_cnt_pkg;
   localparam int NUM_CNT = 5;
   localparam int SEL_W   = 3;

   // Select codes: also the bit index in cnt_en / ovf_evt and the slot in cnt_val
   typedef enum logic [SEL_W-1:0] {
      CNT_CPI   = 3'd0,
      CNT_EXC   = 3'd1,
      CNT_SLEEP = 3'd2,
      CNT_LSU   = 3'd3,
      CNT_FOLD  = 3'd4
   } cnt_id_e;
endpackage

// File: rtl/prof_cnt_qual.sv
module prof_cnt_qual
   import prof_cnt_pkg::*;
#(
   parameter int INC_W = 2
) (
   input  logic                               cpi_extra,
   input  logic                               fetch_stall,
   input  logic                               exc_cycle,
   input  logic                               sleep_cycle,
   input  logic                               lsu_extra,
   input  logic [INC_W-1:0]                   fold_num,
   output logic [NUM_CNT-1:0][INC_W-1:0]      inc_amt
);

   // Per-counter increment amount for this cycle; only the folded slot may exceed 1
   always_comb begin
      inc_amt            = '0;
      inc_amt[CNT_CPI]   = INC_W'(cpi_extra | fetch_stall);
      inc_amt[CNT_EXC]   = INC_W'(exc_cycle);
      inc_amt[CNT_SLEEP] = INC_W'(sleep_cycle);
      inc_amt[CNT_LSU]   = INC_W'(lsu_extra);
      inc_amt[CNT_FOLD]  = fold_num;
   end

endmodule

// File: rtl/prof_cnt_slice.sv
module prof_cnt_slice #(
   parameter int CNT_W = 8,
   parameter int INC_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [INC_W-1:0] inc,
   input  logic             wr_hit,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] val,
   output logic             evt
);

   localparam int SUM_W = CNT_W + 1;

   generate
      if (INC_W > CNT_W) begin : g_bad_inc
         $error("prof_cnt_slice: INC_W must not exceed CNT_W");
      end
   endgenerate

   logic             en_q;
   logic             en_rise;
   logic [SUM_W-1:0] sum;

   assign en_rise = en & ~en_q;
   assign sum     = {1'b0, val} + {{(SUM_W-INC_W){1'b0}}, inc};

   // Priority: enable rising edge clear, then software load, then counting
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= 1'b0;
         val  <= '0;
         evt  <= 1'b0;
      end else begin
         en_q <= en;
         evt  <= 1'b0;
         if (en_rise) begin
            val <= '0;
         end else if (wr_hit) begin
            val <= wr_data;
         end else if (en) begin
            val <= sum[CNT_W-1:0];
            evt <= sum[CNT_W];
         end
      end
   end

   AST_RISE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !en_q) |=> (val == '0 && !evt));                               // R2

   AST_EVT_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      evt |-> (val < $past(val)));                                          // R4

   AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !(en && !en_q)) |=> (val == $past(wr_data) && !evt));      // R6

   AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !wr_hit) |=> ($stable(val) && !evt));                         // R7

endmodule

// File: rtl/prof_cnt_bank.sv
module prof_cnt_bank
   import prof_cnt_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int FOLD_W      = 2,
   parameter bit IMPLEMENTED = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [4:0]                 cnt_en,
   input  logic                       cpi_extra,
   input  logic                       fetch_stall,
   input  logic                       exc_cycle,
   input  logic                       sleep_cycle,
   input  logic                       lsu_extra,
   input  logic [FOLD_W-1:0]          fold_num,
   input  logic                       wr_en,
   input  logic [2:0]                 wr_sel,
   input  logic [CNT_W-1:0]           wr_data,
   output logic [5*CNT_W-1:0]         cnt_val,
   output logic [4:0]                 ovf_evt
);

   localparam int VAL_W = NUM_CNT * CNT_W;

   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("prof_cnt_bank: CNT_W must be at least 2");
      end
      if (FOLD_W < 1 || FOLD_W > CNT_W) begin : g_bad_fold
         $error("prof_cnt_bank: FOLD_W must lie in 1..CNT_W");
      end
      if (VAL_W != $bits(cnt_val)) begin : g_bad_map
         $error("prof_cnt_bank: counter count does not match port width");
      end
   endgenerate

   generate
      if (IMPLEMENTED) begin : g_live
         logic [NUM_CNT-1:0][FOLD_W-1:0] inc_amt;
         logic [NUM_CNT-1:0]             wr_hit;

         prof_cnt_qual #(.INC_W(FOLD_W)) u_qual (
            .cpi_extra  (cpi_extra),
            .fetch_stall(fetch_stall),
            .exc_cycle  (exc_cycle),
            .sleep_cycle(sleep_cycle),
            .lsu_extra  (lsu_extra),
            .fold_num   (fold_num),
            .inc_amt    (inc_amt)
         );

         for (genvar k = 0; k < NUM_CNT; k++) begin : g_slot
            assign wr_hit[k] = wr_en && (wr_sel == SEL_W'(k));

            prof_cnt_slice #(.CNT_W(CNT_W), .INC_W(FOLD_W)) u_slice (
               .clk    (clk),
               .rst_n  (rst_n),
               .en     (cnt_en[k]),
               .inc    (inc_amt[k]),
               .wr_hit (wr_hit[k]),
               .wr_data(wr_data),
               .val    (cnt_val[k*CNT_W +: CNT_W]),
               .evt    (ovf_evt[k])
            );
         end

         AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(wr_hit));                                              // R11

         AST_BAD_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel >= SEL_W'(NUM_CNT) && cnt_en == '0) |=> $stable(cnt_val)); // R11
      end else begin : g_absent
         assign cnt_val = '0;
         assign ovf_evt = '0;
      end
   endgenerate

endmodule

// File: tb/prof_cnt_bank_tb.sv
module prof_cnt_bank_tb;
   localparam int CW = 8;
   localparam int FW = 2;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [4:0]    cnt_en;
   logic          cpi_extra, fetch_stall, exc_cycle, sleep_cycle, lsu_extra;
   logic [FW-1:0] fold_num;
   logic          wr_en;
   logic [2:0]    wr_sel;
   logic [CW-1:0] wr_data;
   logic [5*CW-1:0] cnt_val, off_val;
   logic [4:0]    ovf_evt, off_evt;

   int tests = 0;
   int fails = 0;
   bit off_seen = 1'b0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   prof_cnt_bank #(.CNT_W(CW), .FOLD_W(FW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cpi_extra(cpi_extra),
      .fetch_stall(fetch_stall), .exc_cycle(exc_cycle), .sleep_cycle(sleep_cycle),
      .lsu_extra(lsu_extra), .fold_num(fold_num), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .cnt_val(cnt_val), .ovf_evt(ovf_evt));

   prof_cnt_bank #(.CNT_W(CW), .FOLD_W(FW), .IMPLEMENTED(1'b0)) u_dut_off (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cpi_extra(cpi_extra),
      .fetch_stall(fetch_stall), .exc_cycle(exc_cycle), .sleep_cycle(sleep_cycle),
      .lsu_extra(lsu_extra), .fold_num(fold_num), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .cnt_val(off_val), .ovf_evt(off_evt));

   always @(negedge clk) if (rst_n && (off_val != '0 || off_evt != '0)) off_seen = 1'b1;

   function automatic int val_of(input int k);
      return int'(cnt_val[k*CW +: CW]);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick(); @(negedge clk); endtask

   task automatic clear_quals();
      cpi_extra = 0; fetch_stall = 0; exc_cycle = 0; sleep_cycle = 0;
      lsu_extra = 0; fold_num = '0; wr_en = 0;
   endtask

   task automatic t_reset();
      for (int k = 0; k < 5; k++) chk("R1 value", val_of(k), 0);
      chk("R1 strobes", int'(ovf_evt), 0);
   endtask

   task automatic t_cpi();
      cnt_en[0] = 1; cpi_extra = 1; tick();
      chk("R2 clear on enable", val_of(0), 0);
      tick(); tick(); tick();
      chk("R3 extra cycles", val_of(0), 3);
      cpi_extra = 0; fetch_stall = 1; tick(); tick();
      chk("R3 fetch stalls", val_of(0), 5);
      cpi_extra = 1; tick();
      chk("R3 both qualifiers add one", val_of(0), 6);
      clear_quals();
   endtask

   task automatic t_lsu();
      cnt_en[3] = 1; tick();
      lsu_extra = 0; tick(); lsu_extra = 1; tick(); tick(); tick();
      chk("R5 four-cycle access", val_of(3), 3);
      lsu_extra = 0; tick(); lsu_extra = 1; tick();
      chk("R5 two-cycle access", val_of(3), 4);
      clear_quals();
   endtask

   task automatic t_exc_sleep();
      cnt_en[1] = 1; cnt_en[2] = 1; tick();
      exc_cycle = 1; sleep_cycle = 1; tick(); tick();
      sleep_cycle = 0; tick(); tick(); tick();
      chk("R9 exception count", val_of(1), 5);
      chk("R9 sleep count", val_of(2), 2);
      chk("R9 other counter untouched", val_of(0), 6);
      clear_quals();
   endtask

   task automatic t_wrap();
      wr_en = 1; wr_sel = 3'd0; wr_data = 8'd254; tick(); wr_en = 0;
      chk("R6 load value", val_of(0), 254);
      chk("R6 no strobe on load", int'(ovf_evt[0]), 0);
      cpi_extra = 1; tick();
      chk("R4 reach top", val_of(0), 255);
      chk("R4 no early strobe", int'(ovf_evt[0]), 0);
      tick();
      chk("R4 wrap value", val_of(0), 0);
      chk("R4 strobe on wrap", int'(ovf_evt[0]), 1);
      cpi_extra = 0; tick();
      chk("R4 strobe lasts one cycle", int'(ovf_evt[0]), 0);
      wr_en = 1; wr_data = 8'd255; tick();
      wr_data = 8'h10; cpi_extra = 1; tick();
      chk("R6 load beats increment", val_of(0), 16);
      chk("R6 no strobe at top", int'(ovf_evt[0]), 0);
      clear_quals();
   endtask

   task automatic t_fold();
      cnt_en[4] = 1; tick();
      wr_en = 1; wr_sel = 3'd4; wr_data = 8'd254; tick(); wr_en = 0;
      fold_num = 2'd3; tick();
      chk("R8 step over wrap", val_of(4), 1);
      chk("R8 carry strobe", int'(ovf_evt[4]), 1);
      fold_num = 2'd2; tick();
      chk("R8 add two", val_of(4), 3);
      chk("R8 no strobe", int'(ovf_evt[4]), 0);
      clear_quals();
   endtask

   task automatic t_disabled();
      cnt_en[0] = 0; cpi_extra = 1; tick(); tick();
      chk("R7 disabled holds", val_of(0), 16);
      chk("R7 disabled no strobe", int'(ovf_evt[0]), 0);
      wr_en = 1; wr_sel = 3'd0; wr_data = 8'h33; tick();
      chk("R7 write while disabled", val_of(0), 51);
      wr_data = 8'h44; cnt_en[0] = 1; tick();
      chk("R2 clear beats write", val_of(0), 0);
      clear_quals();
   endtask

   task automatic t_badsel();
      int snap[5];
      for (int k = 0; k < 5; k++) snap[k] = val_of(k);
      wr_en = 1; wr_data = 8'hAA; wr_sel = 3'd5; tick();
      wr_sel = 3'd7; tick(); wr_en = 0; tick();
      for (int k = 0; k < 5; k++) chk("R11 unused select", val_of(k), snap[k]);
   endtask

   task automatic t_off();
      wr_en = 1; wr_sel = 3'd0; wr_data = 8'h55; tick(); wr_en = 0;
      chk("R10 absent values", int'(off_val != '0), 0);
      chk("R10 absent strobes", int'(off_evt), 0);
      chk("R10 never active", int'(off_seen), 0);
   endtask

   initial begin
      rst_n = 0; cnt_en = '0; wr_sel = '0; wr_data = '0;
      clear_quals();
      repeat (3) @(negedge clk);
      rst_n = 1;
      tick();
      t_reset();
      t_cpi();
      t_lsu();
      t_exc_sleep();
      t_wrap();
      t_fold();
      t_disabled();
      t_badsel();
      t_off();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule